// File: doc/BRIEF.md
# USB IN Endpoint Handshake Controller

This block chooses the answer a USB device gives to each IN token on one IN endpoint. It keeps the endpoint's control state: the transfer kind, the transmit FIFO index, a stall flag, a NAK flag, and a single bit. That bit is the frame-parity select on isochronous endpoints and the data-toggle PID on the other kinds.

Each IN token produces exactly one registered answer one cycle later. The answer is STALL, NAK, a zero-length packet, or data tagged DATA0 or DATA1. The stall flag outranks every NAK source. How the stall flag clears depends on the endpoint kind. The NAK flag changes only through dedicated set and clear strobes. After a non-isochronous data packet, an acknowledge pulse flips the toggle bit.

Packet serialization, CRC, the FIFO storage and bus timing belong to neighbouring blocks.

Top module: `usb_in_ep_hs`

## Requirements
- R1: After reset, resp_valid_o is 0, and stall_o, nak_o, pid_bit_o, ep_type_o and fifo_num_o are all 0.
- R2: A cfg_wr_i pulse loads ep_type_i and fifo_num_i, and both are visible on ep_type_o and fifo_num_o one cycle later. The type encoding is 00 control, 01 isochronous, 10 bulk, 11 interrupt.
- R3: An in_token_i pulse gives resp_valid_o high for exactly one cycle, in the cycle after the token. resp_o is encoded 1 STALL, 2 NAK, 3 zero-length packet, 4 DATA0, 5 DATA1. With no token, resp_valid_o stays low.
- R4: While stall_o is 1, every token is answered STALL, regardless of nak_o and global_nak_i.
- R5: On a control endpoint, setup_i clears the stall flag and stall_clr_i has no effect.
- R6: On bulk, interrupt and isochronous endpoints, stall_clr_i clears the stall flag and setup_i has no effect. On every kind, stall_set_i wins over a clear in the same cycle.
- R7: nak_set_i sets nak_o and nak_clr_i clears it. When both are strobed in the same cycle, nak_o ends up 1.
- R8: Without a stall, a token is answered NAK whenever nak_o or global_nak_i is 1.
- R9: On non-isochronous endpoints with no stall and no NAK source active, a token is answered DATA0 or DATA1 (following pid_bit_o) when fifo_avail_i is 1, and NAK when it is 0.
- R10: On isochronous endpoints with no stall and no NAK source active, a token is answered DATA0 only when frame_odd_i equals pid_bit_o and fifo_avail_i is 1. Otherwise the answer is a zero-length packet.
- R11: pid_d0_i forces pid_bit_o to 0. pid_wr_i loads pid_val_i into it. If both arrive in the same cycle, pid_d0_i wins.
- R12: A xfer_ack_i pulse that follows a non-isochronous data answer (with no token in between) flips pid_bit_o. An acknowledge after a NAK, a STALL, or an isochronous answer leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Load endpoint type and FIFO index |
| ep_type_i | input | 2 | Endpoint type to load |
| fifo_num_i | input | 4 | FIFO index to load |
| stall_set_i | input | 1 | Software stall set strobe |
| stall_clr_i | input | 1 | Software stall clear strobe |
| setup_i | input | 1 | SETUP seen on the paired OUT endpoint |
| nak_set_i | input | 1 | Set-NAK strobe |
| nak_clr_i | input | 1 | Clear-NAK strobe |
| pid_d0_i | input | 1 | Force toggle bit to DATA0 |
| pid_wr_i | input | 1 | Load toggle/parity bit |
| pid_val_i | input | 1 | Value for pid_wr_i |
| in_token_i | input | 1 | IN token received |
| frame_odd_i | input | 1 | Least significant bit of current frame number |
| global_nak_i | input | 1 | Device-wide IN NAK |
| fifo_avail_i | input | 1 | Selected FIFO holds a packet |
| xfer_ack_i | input | 1 | Host acknowledged the last packet |
| resp_valid_o | output | 1 | Answer valid |
| resp_o | output | 3 | Answer code |
| stall_o | output | 1 | Stall flag |
| nak_o | output | 1 | NAK flag |
| pid_bit_o | output | 1 | Toggle PID or frame-parity select |
| ep_type_o | output | 2 | Current endpoint type |
| fifo_num_o | output | 4 | Current FIFO index |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the NAK set and clear strobes. The second pair is the forced DATA0 and an acknowledge-driven toggle.

The bench raises both NAK strobes on one clock edge and expects the flag to end up set. It then sends a token and expects a NAK.

The bench also issues pid_d0_i in the same cycle as a qualified acknowledge that would otherwise flip the bit. It expects DATA0 afterwards, and it also checks that the forced DATA0 wins over a simultaneous load of 1.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  typedef enum logic [1:0] {
    EP_CTRL = 2'b00,
    EP_ISO  = 2'b01,
    EP_BULK = 2'b10,
    EP_INTR = 2'b11
  } ep_kind_e;

  typedef enum logic [2:0] {
    HS_NONE  = 3'd0,
    HS_STALL = 3'd1,
    HS_NAK   = 3'd2,
    HS_ZLP   = 3'd3,
    HS_DATA0 = 3'd4,
    HS_DATA1 = 3'd5
  } hs_resp_e;
endpackage

// File: rtl/in_ep_cfg.sv
module in_ep_cfg
  import usb_in_ep_pkg::*;
#(
  parameter int FIFO_NUM_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_wr_i,
  input  logic [1:0]            ep_type_i,
  input  logic [FIFO_NUM_W-1:0] fifo_num_i,
  output ep_kind_e              ep_kind_o,
  output logic [FIFO_NUM_W-1:0] fifo_num_o
);
  ep_kind_e              kind_q;
  logic [FIFO_NUM_W-1:0] fifo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= EP_CTRL;
      fifo_q <= '0;
    end else if (cfg_wr_i) begin
      kind_q <= ep_kind_e'(ep_type_i);
      fifo_q <= fifo_num_i;
    end
  end

  assign ep_kind_o  = kind_q;
  assign fifo_num_o = fifo_q;

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_i |=> $stable(fifo_q) && $stable(kind_q));
endmodule

// File: rtl/in_ep_stall_nak.sv
module in_ep_stall_nak
  import usb_in_ep_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ep_kind_e ep_kind_i,
  input  logic     stall_set_i,
  input  logic     stall_clr_i,
  input  logic     setup_i,
  input  logic     nak_set_i,
  input  logic     nak_clr_i,
  output logic     stall_o,
  output logic     nak_o
);
  logic stall_q, nak_q;
  logic stall_clear;

  // control endpoints leave stall only through SETUP; others only through software
  assign stall_clear = (ep_kind_i == EP_CTRL) ? setup_i : stall_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_q <= 1'b0;
      nak_q   <= 1'b0;
    end else begin
      if (stall_set_i)      stall_q <= 1'b1;
      else if (stall_clear) stall_q <= 1'b0;
      if (nak_set_i)        nak_q <= 1'b1;
      else if (nak_clr_i)   nak_q <= 1'b0;
    end
  end

  assign stall_o = stall_q;
  assign nak_o   = nak_q;

  assert_ctrl_sw_clr_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_kind_i == EP_CTRL && stall_q && !setup_i) |=> stall_q);
  assert_setup_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_kind_i != EP_CTRL && stall_q && !stall_clr_i) |=> stall_q);
  assert_nak_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_set_i |=> nak_q);
endmodule

// File: rtl/in_ep_toggle.sv
module in_ep_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d0_i,
  input  logic wr_i,
  input  logic val_i,
  input  logic ack_i,
  output logic bit_o
);
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bit_q <= 1'b0;
    else if (d0_i)  bit_q <= 1'b0;
    else if (wr_i)  bit_q <= val_i;
    else if (ack_i) bit_q <= ~bit_q;
  end

  assign bit_o = bit_q;

  assert_d0_forces_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d0_i |=> !bit_q);
  assert_ack_flips_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !d0_i && !wr_i) |=> bit_q != $past(bit_q));
endmodule

// File: rtl/in_ep_resp.sv
module in_ep_resp
  import usb_in_ep_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     in_token_i,
  input  ep_kind_e ep_kind_i,
  input  logic     stall_i,
  input  logic     nak_i,
  input  logic     global_nak_i,
  input  logic     fifo_avail_i,
  input  logic     frame_odd_i,
  input  logic     pid_bit_i,
  input  logic     xfer_ack_i,
  output logic     resp_valid_o,
  output hs_resp_e resp_o,
  output logic     ack_ok_o
);
  hs_resp_e dec;
  hs_resp_e resp_q;
  logic     valid_q, pend_q, is_data;

  always_comb begin
    if (stall_i)                    dec = HS_STALL;
    else if (nak_i || global_nak_i) dec = HS_NAK;
    else if (ep_kind_i == EP_ISO)
      dec = (frame_odd_i == pid_bit_i && fifo_avail_i) ? HS_DATA0 : HS_ZLP;
    else if (fifo_avail_i)          dec = pid_bit_i ? HS_DATA1 : HS_DATA0;
    else                            dec = HS_NAK;
  end

  // only a non-iso data answer arms the toggle
  assign is_data  = (dec == HS_DATA0 || dec == HS_DATA1) && ep_kind_i != EP_ISO;
  assign ack_ok_o = xfer_ack_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      resp_q  <= HS_NONE;
      pend_q  <= 1'b0;
    end else begin
      valid_q <= in_token_i;
      if (in_token_i) begin
        resp_q <= dec;
        pend_q <= is_data;
      end else if (ack_ok_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign resp_valid_o = valid_q;
  assign resp_o       = resp_q;

  assert_stall_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_token_i && stall_i) |=> resp_valid_o && resp_o == HS_STALL);
  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_token_i |=> !resp_valid_o);
  assert_nak_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_token_i && !stall_i && (nak_i || global_nak_i)) |=> resp_o == HS_NAK);
  assert_iso_mismatch_zlp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_token_i && !stall_i && !nak_i && !global_nak_i && ep_kind_i == EP_ISO
     && frame_odd_i != pid_bit_i) |=> resp_o == HS_ZLP);
endmodule

// File: rtl/usb_in_ep_hs.sv
module usb_in_ep_hs
  import usb_in_ep_pkg::*;
#(
  parameter int FIFO_NUM_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_wr_i,
  input  logic [1:0]            ep_type_i,
  input  logic [FIFO_NUM_W-1:0] fifo_num_i,
  input  logic                  stall_set_i,
  input  logic                  stall_clr_i,
  input  logic                  setup_i,
  input  logic                  nak_set_i,
  input  logic                  nak_clr_i,
  input  logic                  pid_d0_i,
  input  logic                  pid_wr_i,
  input  logic                  pid_val_i,
  input  logic                  in_token_i,
  input  logic                  frame_odd_i,
  input  logic                  global_nak_i,
  input  logic                  fifo_avail_i,
  input  logic                  xfer_ack_i,
  output logic                  resp_valid_o,
  output logic [2:0]            resp_o,
  output logic                  stall_o,
  output logic                  nak_o,
  output logic                  pid_bit_o,
  output logic [1:0]            ep_type_o,
  output logic [FIFO_NUM_W-1:0] fifo_num_o
);
  ep_kind_e kind;
  hs_resp_e resp;
  logic     stall, nak, pid_bit, ack_ok;

  in_ep_cfg #(.FIFO_NUM_W(FIFO_NUM_W)) u_cfg (
    .clk_i, .rst_ni, .cfg_wr_i, .ep_type_i, .fifo_num_i,
    .ep_kind_o(kind), .fifo_num_o
  );

  in_ep_stall_nak u_sn (
    .clk_i, .rst_ni, .ep_kind_i(kind), .stall_set_i, .stall_clr_i, .setup_i,
    .nak_set_i, .nak_clr_i, .stall_o(stall), .nak_o(nak)
  );

  in_ep_toggle u_tgl (
    .clk_i, .rst_ni, .d0_i(pid_d0_i), .wr_i(pid_wr_i), .val_i(pid_val_i),
    .ack_i(ack_ok), .bit_o(pid_bit)
  );

  in_ep_resp u_resp (
    .clk_i, .rst_ni, .in_token_i, .ep_kind_i(kind), .stall_i(stall), .nak_i(nak),
    .global_nak_i, .fifo_avail_i, .frame_odd_i, .pid_bit_i(pid_bit), .xfer_ack_i,
    .resp_valid_o, .resp_o(resp), .ack_ok_o(ack_ok)
  );

  assign resp_o    = resp;
  assign stall_o   = stall;
  assign nak_o     = nak;
  assign pid_bit_o = pid_bit;
  assign ep_type_o = kind;
endmodule

// File: tb/tb_usb_in_ep_hs.sv
module tb_usb_in_ep_hs;
  logic clk = 0, rst_ni = 0;
  logic cfg_wr = 0; logic [1:0] ep_type = 0; logic [3:0] fifo_num = 0;
  logic stall_set = 0, stall_clr = 0, setup = 0, nak_set = 0, nak_clr = 0;
  logic pid_d0 = 0, pid_wr = 0, pid_val = 0, in_token = 0, frame_odd = 0;
  logic global_nak = 0, fifo_avail = 0, xfer_ack = 0;
  logic resp_valid, stall_o, nak_o, pid_bit; logic [2:0] resp; logic [1:0] type_o;
  logic [3:0] fifo_o;
  int checks = 0, fails = 0;

  localparam int STALL = 1, NAK = 2, ZLP = 3, D0 = 4, D1 = 5;

  always #10 clk = ~clk;

  usb_in_ep_hs dut (
    .clk_i(clk), .rst_ni, .cfg_wr_i(cfg_wr), .ep_type_i(ep_type), .fifo_num_i(fifo_num),
    .stall_set_i(stall_set), .stall_clr_i(stall_clr), .setup_i(setup),
    .nak_set_i(nak_set), .nak_clr_i(nak_clr), .pid_d0_i(pid_d0), .pid_wr_i(pid_wr),
    .pid_val_i(pid_val), .in_token_i(in_token), .frame_odd_i(frame_odd),
    .global_nak_i(global_nak), .fifo_avail_i(fifo_avail), .xfer_ack_i(xfer_ack),
    .resp_valid_o(resp_valid), .resp_o(resp), .stall_o, .nak_o, .pid_bit_o(pid_bit),
    .ep_type_o(type_o), .fifo_num_o(fifo_o)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic cfg(int t, int f);
    @(negedge clk); cfg_wr = 1; ep_type = 2'(t); fifo_num = 4'(f);
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic tok(logic avail, logic gnak, logic odd, int exp, string req);
    @(negedge clk); in_token = 1; fifo_avail = avail; global_nak = gnak; frame_odd = odd;
    @(negedge clk); in_token = 0; global_nak = 0;
    chk({req, " valid"}, resp_valid, 1);
    chk({req, " resp"}, resp, exp);
    @(negedge clk);
    chk("R3 one-cycle", resp_valid, 0);
  endtask

  task automatic ack();
    @(negedge clk); xfer_ack = 1;
    @(negedge clk); xfer_ack = 0;
  endtask

  task automatic t_reset();
    chk("R1 valid", resp_valid, 0); chk("R1 stall", stall_o, 0);
    chk("R1 nak", nak_o, 0); chk("R1 pid", pid_bit, 0);
    chk("R1 type", type_o, 0); chk("R1 fifo", fifo_o, 0);
  endtask

  task automatic t_cfg();
    cfg(2, 5);
    chk("R2 type", type_o, 2); chk("R2 fifo", fifo_o, 5);
  endtask

  task automatic t_bulk();
    cfg(2, 5);
    tok(1, 0, 0, D0, "R9 data0");
    ack(); chk("R12 toggle", pid_bit, 1);
    tok(1, 0, 0, D1, "R9 data1");
    tok(0, 0, 0, NAK, "R9 empty");
    ack(); chk("R12 ack after nak", pid_bit, 1);
  endtask

  task automatic t_nak();
    @(negedge clk); nak_set = 1; nak_clr = 1;
    @(negedge clk); nak_set = 0; nak_clr = 0;
    chk("R7 both", nak_o, 1);
    tok(1, 0, 0, NAK, "R8 ep nak");
    @(negedge clk); nak_clr = 1; @(negedge clk); nak_clr = 0;
    chk("R7 clr", nak_o, 0);
    tok(1, 1, 0, NAK, "R8 global");
  endtask

  task automatic t_stall_bulk();
    cfg(3, 1);
    @(negedge clk); stall_set = 1; nak_set = 1; @(negedge clk); stall_set = 0; nak_set = 0;
    tok(1, 1, 0, STALL, "R4 prio");
    @(negedge clk); setup = 1; @(negedge clk); setup = 0;
    chk("R6 setup ignored", stall_o, 1);
    @(negedge clk); stall_clr = 1; @(negedge clk); stall_clr = 0;
    chk("R6 sw clr", stall_o, 0);
    @(negedge clk); stall_clr = 1; stall_set = 1; @(negedge clk); stall_clr = 0; stall_set = 0;
    chk("R6 set wins", stall_o, 1);
    @(negedge clk); stall_clr = 1; nak_clr = 1; @(negedge clk); stall_clr = 0; nak_clr = 0;
  endtask

  task automatic t_stall_ctrl();
    cfg(0, 0);
    @(negedge clk); stall_set = 1; @(negedge clk); stall_set = 0;
    @(negedge clk); stall_clr = 1; @(negedge clk); stall_clr = 0;
    chk("R5 sw clr ignored", stall_o, 1);
    tok(1, 0, 0, STALL, "R4 ctrl");
    @(negedge clk); setup = 1; @(negedge clk); setup = 0;
    chk("R5 setup clr", stall_o, 0);
  endtask

  task automatic t_iso();
    cfg(1, 2);
    @(negedge clk); pid_wr = 1; pid_val = 0; @(negedge clk); pid_wr = 0;
    tok(1, 0, 0, D0, "R10 even match");
    ack(); chk("R12 iso no toggle", pid_bit, 0);
    tok(1, 0, 1, ZLP, "R10 mismatch");
    @(negedge clk); pid_wr = 1; pid_val = 1; @(negedge clk); pid_wr = 0;
    chk("R11 write", pid_bit, 1);
    tok(1, 0, 1, D0, "R10 odd match");
    tok(0, 0, 1, ZLP, "R10 empty");
  endtask

  task automatic t_pid();
    cfg(2, 3);
    @(negedge clk); pid_wr = 1; pid_val = 1; @(negedge clk); pid_wr = 0;
    tok(1, 0, 0, D1, "R9 data1 preset");
    @(negedge clk); xfer_ack = 1; pid_d0 = 1; @(negedge clk); xfer_ack = 0; pid_d0 = 0;
    chk("R11 d0 over ack", pid_bit, 0);
    @(negedge clk); pid_wr = 1; pid_val = 1; pid_d0 = 1;
    @(negedge clk); pid_wr = 0; pid_d0 = 0;
    chk("R11 d0 over write", pid_bit, 0);
    tok(1, 0, 0, D0, "R9 after d0");
    tok(1, 0, 0, D0, "R12 no ack keeps");
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_bulk();
    t_nak();
    t_stall_bulk();
    t_stall_ctrl();
    t_iso();
    t_pid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule